// File: doc/BRIEF.md
# Video Word Parity Guard

This block protects parallel video words with two parity bits. On the transmit path it registers each valid word and places two even-parity bits above it. The low parity bit covers the lower half of the active data bits. The high parity bit covers the upper half. On the receive path it recomputes both bits for each incoming extended word and compares them with the bits that arrived. Each word that carries a mismatch adds one to a saturating error counter.

An alarm pin, active low, falls once the count rises above a programmable threshold. A clear strobe empties the counter and releases the alarm. Parity is used only when the configured word width is between 1 and 16 bits. With any other width, or with the enable bit low, words pass through unchanged and the counter is frozen.

The configured width is an input count of active data bits. For a width `w`, the lower half is bits `0 .. w/2-1` (integer division), and the upper half is bits `w/2 .. w-1`. Bits at or above `w` are carried along but take no part in parity.

Top module: `vparity_guard`

## Requirements
- R1: When parity is active and `tx_valid` is high, at the next rising edge `tx_ext[23:0]` takes `tx_word` unchanged. `tx_ext[24]` takes the XOR of data bits `0 .. w/2-1`, and `tx_ext[25]` takes the XOR of bits `w/2 .. w-1`. `tx_ext_vld` is high for exactly the cycle after each `tx_valid` cycle, and `tx_ext` holds when no word is valid.
- R2: Parity is active only when `par_en` is 1 and `word_width` is in 1..16. Otherwise a valid transmit word appears as `{2'b00, tx_word}`.
- R3: While parity is active, each `rx_valid` word whose received bits `rx_ext[25:24]` differ from the recomputed pair adds exactly one to `err_cnt` at the next edge. This holds whether one bit or both bits differ. A matching word leaves the count unchanged.
- R4: While parity is inactive, `err_cnt` holds its value whatever arrives on the receive path.
- R5: `err_cnt` saturates at 0xFFFF and does not wrap.
- R6: `err_clr` high sets `err_cnt` to 0 at the next edge. This takes precedence over an error detected in the same cycle, and that error is not counted.
- R7: `err_n` is registered. At each edge without a clear, it becomes 0 if the count before that edge was strictly greater than `err_thresh`, and 1 otherwise. A count equal to the threshold keeps it high.
- R8: `err_clr` high drives `err_n` to 1 at the next edge.
- R9: While `rst_n` is low, every edge gives `err_cnt` = 0, `err_n` = 1, `tx_ext` = 0 and `tx_ext_vld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| par_en | input | 1 | Parity enable |
| word_width | input | 5 | Number of active data bits |
| tx_valid | input | 1 | Transmit word valid |
| tx_word | input | 24 | Transmit data word |
| tx_ext | output | 26 | Registered word with parity pair in bits 25:24 |
| tx_ext_vld | output | 1 | `tx_ext` carries a new word |
| rx_valid | input | 1 | Receive extended word valid |
| rx_ext | input | 26 | Received word, parity pair in bits 25:24 |
| err_thresh | input | 16 | Alarm threshold |
| err_clr | input | 1 | Clear strobe for counter and alarm |
| err_cnt | output | 16 | Parity error count |
| err_n | output | 1 | Alarm, low when count exceeds threshold |

## Verification
A clear strobe and a detected receive error can fall in the same cycle. The bench forces this by raising `err_clr` while a word with a corrupted parity pair is valid, both at a directed point and at random during a mixed traffic phase. The result is judged at the following falling edge. The count must read zero and the alarm must be high, which shows the clear won and the coincident error was dropped. The per-cycle model applies the same precedence on every clock, so any other ordering shows up as a count mismatch.

// File: rtl/vpg_pkg.sv
// Shared constants and types for the video word parity guard.
package vpg_pkg;
    // Widest word for which parity may be enabled.
    localparam int unsigned PAR_LIMIT_W = 16;

    // Parity pair as carried above the data bits: hi at the top.
    typedef struct packed {
        logic hi;
        logic lo;
    } par_pair_t;
endpackage

// File: rtl/vpg_par_calc.sv
// Combinational even-parity pair over a word of configurable width.
// Assumes width <= MAX_W when the result is used; bits at or above
// width are excluded. lo covers bits [0, width/2), hi covers
// bits [width/2, width).
module vpg_par_calc
    import vpg_pkg::*;
#(
    parameter int MAX_W = 24,
    parameter int WW    = 5
) (
    input  logic [MAX_W-1:0] word,
    input  logic [WW-1:0]    width,
    output par_pair_t        par
);
    logic [WW-1:0] half;

    // Split point and per-half XOR reduction.
    always_comb begin
        half   = width >> 1;
        par.lo = 1'b0;
        par.hi = 1'b0;
        for (int i = 0; i < MAX_W; i++) begin
            if (WW'(i) < half)
                par.lo = par.lo ^ word[i];
            else if (WW'(i) < width)
                par.hi = par.hi ^ word[i];
        end
    end
endmodule

// File: rtl/vpg_tx_stage.sv
// Transmit register stage: latches a valid word and appends the parity
// pair (or zeros when parity is inactive). Assumes par is computed
// from tx_word in the same cycle.
module vpg_tx_stage
    import vpg_pkg::*;
#(
    parameter int MAX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tx_valid,
    input  logic [MAX_W-1:0] tx_word,
    input  par_pair_t        par,
    output logic [MAX_W+1:0] tx_ext,
    output logic             tx_ext_vld
);
    // Latch the extended word on each valid cycle, flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ext     <= '0;
            tx_ext_vld <= 1'b0;
        end else begin
            tx_ext_vld <= tx_valid;
            if (tx_valid)
                tx_ext <= active ? {par, tx_word} : {2'b00, tx_word};
        end
    end
endmodule

// File: rtl/vpg_err_count.sv
// Saturating parity error counter with a registered threshold alarm.
// Assumes err_pulse is already qualified by valid and parity-active.
// The clear strobe wins over a coincident error and releases the alarm.
module vpg_err_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt,
    output logic             err_n
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count mismatched words, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (err_pulse && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    // Alarm follows the counter one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_n <= 1'b1;
        else if (clr)
            err_n <= 1'b1;
        else
            err_n <= !(cnt > thresh);
    end
endmodule

// File: rtl/vparity_guard.sv
// Video word parity guard: two-bit parity insertion on transmit,
// recheck, error counting and threshold alarm on receive.
// Assumes a single clock domain and a synchronous active-low reset.
module vparity_guard
    import vpg_pkg::*;
#(
    parameter  int MAX_W = 24,
    parameter  int CNT_W = 16,
    localparam int WW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_en,
    input  logic [WW-1:0]    word_width,
    input  logic             tx_valid,
    input  logic [MAX_W-1:0] tx_word,
    output logic [MAX_W+1:0] tx_ext,
    output logic             tx_ext_vld,
    input  logic             rx_valid,
    input  logic [MAX_W+1:0] rx_ext,
    input  logic [CNT_W-1:0] err_thresh,
    input  logic             err_clr,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_n
);
    localparam int LIM_W = (MAX_W < int'(PAR_LIMIT_W)) ? MAX_W : int'(PAR_LIMIT_W);

    logic      active;
    logic      rx_bad;
    par_pair_t tx_par;
    par_pair_t rx_par;
    par_pair_t rx_got;

    // Parity applies only for an enabled, supported word width.
    always_comb begin
        active = par_en && (word_width != '0) && (word_width <= WW'(LIM_W));
    end

    vpg_par_calc #(.MAX_W(MAX_W), .WW(WW)) u_tx_calc (
        .word  (tx_word),
        .width (word_width),
        .par   (tx_par)
    );

    vpg_par_calc #(.MAX_W(MAX_W), .WW(WW)) u_rx_calc (
        .word  (rx_ext[MAX_W-1:0]),
        .width (word_width),
        .par   (rx_par)
    );

    // Qualify a receive mismatch on either parity bit.
    always_comb begin
        rx_got = rx_ext[MAX_W+1:MAX_W];
        rx_bad = rx_valid && active && (rx_got != rx_par);
    end

    vpg_tx_stage #(.MAX_W(MAX_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .tx_valid   (tx_valid),
        .tx_word    (tx_word),
        .par        (tx_par),
        .tx_ext     (tx_ext),
        .tx_ext_vld (tx_ext_vld)
    );

    vpg_err_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (rx_bad),
        .clr       (err_clr),
        .thresh    (err_thresh),
        .cnt       (err_cnt),
        .err_n     (err_n)
    );
endmodule

// File: rtl/vpg_checker.sv
// Temporal properties of the parity guard, observed at its ports.
module vpg_checker #(
    parameter int MAX_W = 24,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             par_en,
    input logic             tx_valid,
    input logic             tx_ext_vld,
    input logic             err_clr,
    input logic [CNT_W-1:0] err_thresh,
    input logic [CNT_W-1:0] err_cnt,
    input logic             err_n
);
    AST_TX_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tx_ext_vld == $past(tx_valid)));                        // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (err_cnt == $past(err_cnt)) ||
                     (err_cnt == CNT_W'($past(err_cnt) + 1'b1)));          // R3
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_en && !err_clr) |=> $stable(err_cnt));                       // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == '1 && !err_clr) |=> (err_cnt == '1));                  // R5
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_cnt == '0));                                      // R6
    AST_ALARM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (err_n == ($past(err_cnt) <= $past(err_thresh))));    // R7
    AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> err_n);                                                // R8
endmodule

bind vparity_guard vpg_checker #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_en     (par_en),
    .tx_valid   (tx_valid),
    .tx_ext_vld (tx_ext_vld),
    .err_clr    (err_clr),
    .err_thresh (err_thresh),
    .err_cnt    (err_cnt),
    .err_n      (err_n)
);

// File: tb/vparity_guard_tb.sv
// Self-checking bench: behavioural per-cycle model plus directed checks.
module vparity_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 24;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          par_en;
    logic [4:0]    word_width;
    logic          tx_valid;
    logic [MW-1:0] tx_word;
    logic [MW+1:0] tx_ext;
    logic          tx_ext_vld;
    logic          rx_valid;
    logic [MW+1:0] rx_ext;
    logic [CW-1:0] err_thresh;
    logic          err_clr;
    logic [CW-1:0] err_cnt;
    logic          err_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc_cnt  = 0;
    bit  done     = 1'b0;

    // Model state
    logic [MW+1:0] m_ext;
    logic          m_vld;
    int            m_cnt;
    logic          m_errn;

    vparity_guard u_dut (
        .clk(clk), .rst_n(rst_n), .par_en(par_en), .word_width(word_width),
        .tx_valid(tx_valid), .tx_word(tx_word), .tx_ext(tx_ext),
        .tx_ext_vld(tx_ext_vld), .rx_valid(rx_valid), .rx_ext(rx_ext),
        .err_thresh(err_thresh), .err_clr(err_clr), .err_cnt(err_cnt),
        .err_n(err_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] ref_par(input logic [MW-1:0] w, input int width);
        logic lo = 1'b0;
        logic hi = 1'b0;
        for (int i = 0; i < MW; i++) begin
            if (i < width / 2) lo ^= w[i];
            else if (i < width) hi ^= w[i];
        end
        return {hi, lo};
    endfunction

    function automatic bit ref_active(input logic en, input int width);
        return en && width >= 1 && width <= 16;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model advances on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ext = '0; m_vld = 1'b0; m_cnt = 0; m_errn = 1'b1;
        end else begin
            m_errn = err_clr ? 1'b1 : !(m_cnt > int'(err_thresh));
            if (err_clr)
                m_cnt = 0;
            else if (rx_valid && ref_active(par_en, int'(word_width)) &&
                     rx_ext[MW+1:MW] != ref_par(rx_ext[MW-1:0], int'(word_width)) &&
                     m_cnt < 65535)
                m_cnt = m_cnt + 1;
            m_vld = tx_valid;
            if (tx_valid)
                m_ext = ref_active(par_en, int'(word_width)) ?
                        {ref_par(tx_word, int'(word_width)), tx_word} : {2'b00, tx_word};
        end
    end

    // Compare DUT to model on every falling edge.
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            chk("R1 tx_ext model", 32'(tx_ext), 32'(m_ext));
            chk("R1 tx_ext_vld model", 32'(tx_ext_vld), 32'(m_vld));
            chk("R3 err_cnt model", 32'(err_cnt), 32'(m_cnt));
            chk("R7 err_n model", 32'(err_n), 32'(m_errn));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send_tx(input string req, input logic [MW-1:0] w, input logic [MW+1:0] exp);
        tx_valid = 1'b1; tx_word = w;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(req, 32'(tx_ext), 32'(exp));
        chk(req, 32'(tx_ext_vld), 32'd1);
    endtask

    task automatic send_rx(input logic [MW-1:0] w, input logic [1:0] flip);
        rx_valid = 1'b1;
        rx_ext = {ref_par(w, int'(word_width)) ^ flip, w};
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; par_en = 1'b0; word_width = 5'd16; tx_valid = 1'b0;
        tx_word = '0; rx_valid = 1'b0; rx_ext = '0; err_thresh = 16'd2;
        err_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 cnt", 32'(err_cnt), 32'd0);
        chk("R9 err_n", 32'(err_n), 32'd1);
        chk("R9 tx_ext", 32'(tx_ext), 32'd0);
        chk("R9 vld", 32'(tx_ext_vld), 32'd0);
        rst_n = 1'b1;
        par_en = 1'b1;
        @(negedge clk);

        // R1 insertion at width 16 and 5
        send_tx("R1 w16 lo", 24'h000001, 26'h1000001);
        send_tx("R1 w16 hi", 24'h000100, 26'h2000100);
        send_tx("R1 w16 even", 24'h000003, 26'h0000003);
        word_width = 5'd5;
        send_tx("R1 w5", 24'h00001F, 26'h200001F);
        send_tx("R1 w5 bits above width", 24'h0000FF, 26'h20000FF);
        @(negedge clk);
        chk("R1 vld drops", 32'(tx_ext_vld), 32'd0);
        chk("R1 hold", 32'(tx_ext), 32'h20000FF);
        // R2 pass-through
        word_width = 5'd20;
        send_tx("R2 width 20", 24'h000001, 26'h0000001);
        word_width = 5'd16; par_en = 1'b0;
        send_tx("R2 disabled", 24'h000100, 26'h0000100);
        par_en = 1'b1;

        // R3 / R7 counting and alarm lag
        send_rx(24'h00ABCD, 2'b01);
        send_rx(24'h001234, 2'b10);
        @(negedge clk);
        chk("R3 two errors", 32'(err_cnt), 32'd2);
        chk("R7 equal keeps high", 32'(err_n), 32'd1);
        send_rx(24'h000F0F, 2'b01);
        chk("R7 registered lag", 32'(err_n), 32'd1);
        @(negedge clk);
        chk("R7 above threshold", 32'(err_n), 32'd0);
        send_rx(24'h00C0DE, 2'b00);
        chk("R3 good word", 32'(err_cnt), 32'd3);
        send_rx(24'h00BEEF, 2'b11);
        chk("R3 both bits one error", 32'(err_cnt), 32'd4);
        // R4 hold while inactive
        par_en = 1'b0;
        send_rx(24'h000011, 2'b01);
        send_rx(24'h000022, 2'b10);
        chk("R4 disabled hold", 32'(err_cnt), 32'd4);
        par_en = 1'b1; word_width = 5'd20;
        send_rx(24'h000033, 2'b01);
        chk("R4 wide hold", 32'(err_cnt), 32'd4);
        word_width = 5'd16;
        // R6 / R8 clear against coincident error
        err_clr = 1'b1;
        send_rx(24'h000044, 2'b01);
        err_clr = 1'b0;
        chk("R6 clear wins", 32'(err_cnt), 32'd0);
        chk("R8 clear releases", 32'(err_n), 32'd1);

        // R5 saturation
        err_thresh = 16'hFFFF;
        rx_valid = 1'b1;
        rx_ext = {ref_par(24'h000055, 16) ^ 2'b01, 24'h000055};
        repeat (65540) @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R5 saturate", 32'(err_cnt), 32'hFFFF);
        chk("R7 max threshold", 32'(err_n), 32'd1);
        err_thresh = 16'hFFFE;
        @(negedge clk);
        @(negedge clk);
        chk("R7 below max", 32'(err_n), 32'd0);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R8 release after alarm", 32'(err_n), 32'd1);
        chk("R6 cleared", 32'(err_cnt), 32'd0);

        // Mixed random traffic; model compares each cycle
        for (int k = 0; k < 3000; k++) begin
            par_en     = ($urandom_range(0, 9) != 0);
            word_width = 5'($urandom_range(0, 24));
            err_thresh = 16'($urandom_range(0, 12));
            err_clr    = ($urandom_range(0, 40) == 0);
            tx_valid   = $urandom_range(0, 1);
            tx_word    = 24'($urandom);
            rx_valid   = $urandom_range(0, 1);
            rx_ext     = {2'($urandom), 24'($urandom)};
            @(negedge clk);
        end
        tx_valid = 1'b0; rx_valid = 1'b0; err_clr = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule